// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block guesses whether a conditional branch will be taken. It combines the outcomes of the most recently resolved branches, held in a short global history register, with a few bits of the branch's own address. The result selects one saturating up/down counter in a table, and the upper half of that counter's range means "taken". A fetch stage presents a branch PC and gets the guess back in the same cycle, together with the history value that formed the index. When the branch later resolves, that history is passed back with the PC and the real outcome. The counter that was consulted at lookup is trained, and the outcome is shifted into the global history.

A build-time parameter chooses how the index is formed. In concatenating mode the history sits above the address bits, so every history/address pair has its own counter. In hashing mode the history is XORed with an equal number of address bits, which gives a table of 2^HIST_W counters.

Top module: `corr_bpred`

## Requirements
- R1: The global history changes only on a cycle with `up_valid` high. It then shifts left by one and takes the resolved outcome into bit 0 (1 = taken).
- R2: `lk_hist` always shows the current global history, which is the value used to form the lookup index in that cycle.
- R3: `lk_taken` is 1 exactly when the selected counter is at least 2^(CTR_W-1). It is a combinational function of `lk_pc` and the stored state.
- R4: On a taken update the selected counter goes up by one, and it stays at 2^CTR_W-1 once there.
- R5: On a not-taken update the selected counter goes down by one, and it stays at 0 once there.
- R6: After a synchronous active-low reset, every counter holds 2^(CTR_W-1)-1 (weakly not taken) and the history is all zeros.
- R7: In concatenating mode the index is {history, pc[ADDR_W+1:2]}, with the history in the upper bits.
- R8: In hashing mode the index is history XOR pc[HIST_W+1:2], and the table has 2^HIST_W counters.
- R9: An update trains the counter selected by `up_pc` and `up_hist`, not by the current history.
- R10: PC bits 1:0, and the PC bits above the address field, have no effect on the index.
- R11: With CTR_W = 2, a counter in the strongly taken state still predicts taken after one not-taken update. It predicts not taken only after a second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | History used for this lookup; carry it to the update |
| up_valid | input | 1 | A resolved branch is presented for training |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | HIST_W | History captured when this branch was looked up |

## Verification
A wrong counter value stays hidden until some later lookup lands on that entry with a matching history. It then shows as a wrong `lk_taken` in that same cycle, so the bench looks up every cycle and compares against a behavioural model of both index modes. A wrong history is visible at once on `lk_hist` in the cycle after the update. It also moves every later lookup to another entry, so the error spreads quickly into the predictions. Directed sequences cover saturation, the two-miss hysteresis, ignored PC bits and training through a stale history, with literal expected values.

// File: rtl/bp_pkg.sv
// Shared definitions for the correlating direction predictor.
// Assumes PCs are byte addresses of 4-byte aligned instructions.
package bp_pkg;
    // Lowest PC bit that takes part in indexing (skips the byte offset).
    localparam int PC_IDX_LSB = 2;

    // How history and address bits are combined into a table index.
    typedef enum logic {
        IDX_CONCAT = 1'b0,
        IDX_HASH   = 1'b1
    } idx_mode_e;
endpackage

// File: rtl/bp_ghr.sv
// Global outcome history register.
// Shifts in one resolved outcome per valid update, newest at bit 0.
// Assumes HIST_W >= 1.
module bp_ghr #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W:0] widened;

    // Append the new outcome below the existing history bits.
    always_comb widened = {hist, outcome};

    // Hold or shift the history; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= widened[HIST_W-1:0];
    end
endmodule

// File: rtl/bp_index.sv
// Table index former.
// Picks between concatenation and XOR hashing of history and PC bits.
// Assumes IDX_W matches the chosen mode (HIST_W+ADDR_W or HIST_W).
module bp_index
    import bp_pkg::*;
#(
    parameter int        HIST_W   = 2,
    parameter int        ADDR_W   = 4,
    parameter int        PC_W     = 32,
    parameter idx_mode_e IDX_MODE = IDX_CONCAT,
    parameter int        IDX_W    = HIST_W + ADDR_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (IDX_MODE == IDX_HASH) begin : g_hash
            // Fold history onto an equal-width slice of the PC.
            always_comb idx = hist ^ pc[PC_IDX_LSB +: HIST_W];
        end else begin : g_concat
            // History selects the upper half, address the lower.
            always_comb idx = {hist, pc[PC_IDX_LSB +: ADDR_W]};
        end
    endgenerate
endmodule

// File: rtl/bp_pht.sv
// Pattern table of saturating up/down counters.
// One combinational read port for lookup, one read-modify-write port
// for training. Assumes CTR_W >= 1; the update takes effect at the edge.
module bp_pht #(
    parameter int IDX_W = 6,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken,
    output logic [CTR_W-1:0] wr_old,
    output logic [CTR_W-1:0] wr_new
);
    localparam int              DEPTH   = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_MID = CTR_MAX >> 1;

    logic [CTR_W-1:0] ctr_q [DEPTH];

    // Lookup read; the direction is the counter's top bit.
    always_comb begin
        rd_ctr   = ctr_q[rd_idx];
        rd_taken = rd_ctr[CTR_W-1];
    end

    // Saturating next value for the entry being trained.
    always_comb begin
        wr_old = ctr_q[wr_idx];
        if (wr_taken) wr_new = (wr_old == CTR_MAX) ? wr_old : wr_old + 1'b1;
        else          wr_new = (wr_old == '0)      ? wr_old : wr_old - 1'b1;
    end

    // Store counters; reset all to weakly not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_MID;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_new;
        end
    end
endmodule

// File: rtl/corr_bpred.sv
// Global-history correlating branch direction predictor (top).
// Lookup is combinational from lk_pc; training and history shift happen
// at the clock edge when up_valid is high. The caller returns the
// lk_hist value seen at lookup as up_hist.
module corr_bpred
    import bp_pkg::*;
#(
    parameter int        HIST_W   = 2,
    parameter int        ADDR_W   = 4,
    parameter int        CTR_W    = 2,
    parameter int        PC_W     = 32,
    parameter idx_mode_e IDX_MODE = IDX_CONCAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic [HIST_W-1:0] up_hist
);
    localparam int IDX_W = (IDX_MODE == IDX_HASH) ? HIST_W : HIST_W + ADDR_W;

    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] up_idx;
    logic [CTR_W-1:0] lk_ctr;
    logic [CTR_W-1:0] upd_old;
    logic [CTR_W-1:0] upd_new;

    bp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .outcome  (up_taken),
        .hist     (lk_hist)
    );

    bp_index #(
        .HIST_W(HIST_W), .ADDR_W(ADDR_W), .PC_W(PC_W),
        .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
    ) u_lk_idx (
        .pc   (lk_pc),
        .hist (lk_hist),
        .idx  (lk_idx)
    );

    bp_index #(
        .HIST_W(HIST_W), .ADDR_W(ADDR_W), .PC_W(PC_W),
        .IDX_MODE(IDX_MODE), .IDX_W(IDX_W)
    ) u_up_idx (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (up_idx)
    );

    bp_pht #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .rd_taken (lk_taken),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken),
        .wr_old   (upd_old),
        .wr_new   (upd_new)
    );
endmodule

// File: rtl/bp_checker.sv
// Property checker for corr_bpred, attached by bind below.
// Observes history, update traffic and the trained counter values.
module bp_checker #(
    parameter int HIST_W = 2,
    parameter int CTR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HIST_W-1:0] lk_hist,
    input logic              lk_taken,
    input logic              up_valid,
    input logic              up_taken,
    input logic [CTR_W-1:0]  upd_old,
    input logic [CTR_W-1:0]  upd_new
);
    localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

    // R1: a valid update shifts the outcome in at bit 0
    a_r1_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

    // R1: no update, no history change
    a_r1_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R4: taken training never lowers the counter and steps by at most one
    a_r4_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken) |-> (upd_new >= upd_old) && (upd_new - upd_old <= 1));

    // R4: ceiling holds
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && upd_old == CMAX) |-> upd_new == CMAX);

    // R5: not-taken training never raises the counter and steps by at most one
    a_r5_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken) |-> (upd_new <= upd_old) && (upd_old - upd_new <= 1));

    // R5: floor holds
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && upd_old == '0) |-> upd_new == '0);

    // R6: right after reset, empty history and a not-taken guess
    a_r6_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lk_hist == '0) && !lk_taken);
endmodule

bind corr_bpred bp_checker #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_bp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_hist  (lk_hist),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .upd_old  (upd_old),
    .upd_new  (upd_new)
);

// File: tb/tb_corr_bpred.sv
// Bench: runs a concatenating and a hashing instance side by side on the
// same stimulus and compares both against a behavioural model every cycle.
module tb_corr_bpred;
    import bp_pkg::*;

    localparam int K = 2;
    localparam int M = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [K-1:0] up_hist = '0;
    logic        taken_c, taken_h;
    logic [K-1:0] hist_c, hist_h;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state
    int m_cat [64];
    int m_hsh [4];
    int m_hist;

    always #5 clk = ~clk;

    corr_bpred #(.HIST_W(K), .ADDR_W(M), .CTR_W(2), .PC_W(32), .IDX_MODE(IDX_CONCAT)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(taken_c), .lk_hist(hist_c),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

    corr_bpred #(.HIST_W(K), .ADDR_W(M), .CTR_W(2), .PC_W(32), .IDX_MODE(IDX_HASH)) dut_hash (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(taken_h), .lk_hist(hist_h),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

    function automatic int cat_idx(input int h, input logic [31:0] pc);
        return (h * 16) + int'((pc >> 2) & 32'hF);
    endfunction

    function automatic int hsh_idx(input int h, input logic [31:0] pc);
        return (h ^ int'((pc >> 2) & 32'h3)) & 3;
    endfunction

    function automatic int sat(input int v, input logic t);
        if (t) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_cat[i] = 1;
        for (int i = 0; i < 4; i++) m_hsh[i] = 1;
        m_hist = 0;
    endtask

    // Drive one cycle, compare lookups against the model, then advance the model.
    task automatic cycle(input string req, input logic uv, input logic [31:0] upc,
                         input logic ut, input logic [K-1:0] uh, input logic [31:0] lpc);
        @(negedge clk);
        up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh; lk_pc = lpc;
        #1;
        check({req, " concat"}, int'(taken_c), int'(m_cat[cat_idx(m_hist, lpc)] >= 2));
        check({req, " hashed"}, int'(taken_h), int'(m_hsh[hsh_idx(m_hist, lpc)] >= 2));
        check({req, " R2 hist"}, int'(hist_c), m_hist);
        check({req, " R2 hist hashed"}, int'(hist_h), m_hist);
        if (uv) begin
            m_cat[cat_idx(int'(uh), upc)] = sat(m_cat[cat_idx(int'(uh), upc)], ut);
            m_hsh[hsh_idx(int'(uh), upc)] = sat(m_hsh[hsh_idx(int'(uh), upc)], ut);
            m_hist = ((m_hist << 1) | int'(ut)) & 3;
        end
    endtask

    localparam logic [31:0] PA = 32'h0000_0100;   // concat idx 0 / hash idx 0 at hist 00
    localparam logic [31:0] PD = 32'h0000_0204;   // concat idx 1 / hash idx 1 at hist 00

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: every address predicts not taken, history cleared
        for (int i = 0; i < 16; i++) cycle("R6", 1'b0, '0, 1'b0, '0, 32'(i * 4));
        check("R6 literal hist", int'(hist_c), 0);

        // R4 and R5: drive counters to both ends
        cycle("R4", 1'b1, PA, 1'b1, 2'b00, PA);
        cycle("R4", 1'b1, PA, 1'b1, 2'b00, PA);
        cycle("R4", 1'b1, PA, 1'b1, 2'b00, PA);
        cycle("R5", 1'b1, PD, 1'b0, 2'b00, PA);
        cycle("R5", 1'b1, PD, 1'b0, 2'b00, PA);
        // R11: strong taken, first miss keeps taken, second flips
        cycle("R11", 1'b1, PA, 1'b0, 2'b00, PA);
        check("R4 saturated taken concat", int'(taken_c), 1);
        check("R4 saturated taken hashed", int'(taken_h), 1);
        cycle("R11", 1'b1, PA, 1'b0, 2'b00, PA | 32'hF000_0003);
        check("R11 one miss concat", int'(taken_c), 1);
        check("R11 one miss hashed", int'(taken_h), 1);
        check("R10 ignored pc bits", int'(taken_c), 1);
        cycle("R11", 1'b0, '0, 1'b0, 2'b00, PA);
        check("R11 two misses concat", int'(taken_c), 0);
        check("R11 two misses hashed", int'(taken_h), 0);
        cycle("R5", 1'b0, '0, 1'b0, 2'b00, PD);
        check("R5 floor concat", int'(taken_c), 0);

        // R9: training through a history other than the current one
        cycle("R9", 1'b1, PA, 1'b1, 2'b10, PA);
        cycle("R9", 1'b1, PD, 1'b0, 2'b00, PA);
        cycle("R9", 1'b0, '0, 1'b0, 2'b00, PA);
        check("R9 stale history concat", int'(taken_c), 1);
        check("R9 stale history hashed", int'(taken_h), 1);
        check("R1 literal hist 10", int'(hist_c), 2);
        // R7 vs R8: pc 0x130 shares the hashed entry only
        cycle("R8", 1'b0, '0, 1'b0, 2'b00, 32'h0000_0130);
        check("R7 concat separate entry", int'(taken_c), 0);
        check("R8 hashed shared entry", int'(taken_h), 1);

        // R1: outcome pattern t,n,t gives 01
        cycle("R1", 1'b1, 32'h40, 1'b1, 2'b00, 32'h40);
        cycle("R1", 1'b1, 32'h44, 1'b0, 2'b00, 32'h40);
        cycle("R1", 1'b1, 32'h48, 1'b1, 2'b00, 32'h40);
        cycle("R1", 1'b0, '0, 1'b0, 2'b00, 32'h40);
        check("R1 literal hist 01", int'(hist_c), 1);

        // R3 and R10: mixed traffic, history passed back as at lookup or random
        for (int i = 0; i < 400; i++) begin
            logic [31:0] pc;
            logic [K-1:0] h;
            pc = $urandom;
            h  = (i % 3 == 0) ? K'($urandom) : K'(m_hist);
            cycle((i % 2) ? "R3" : "R10", 1'($urandom % 4 != 0), pc & 32'h0000_00FF,
                  1'($urandom % 3 != 0), h, $urandom);
        end

        // R6 again after a mid-run reset
        @(negedge clk); rst_n = 1'b0; up_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 8; i++) cycle("R6", 1'b0, '0, 1'b0, '0, 32'(i * 4));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule